// File: doc/BRIEF.md
# Cell Balancing Mode Controller

This block is the control core for cell discharge balancing in a battery monitor. A host writes and reads its registers over a simple single-cycle port. The registers are:

- a 3-bit balancing mode,
- a switch-select mask,
- a delay setting,
- one expiration time per cell,
- an under-voltage exit threshold.

The block runs a balancing timer and drives one switch-enable line per cell. Cell 1's expiration value has two roles. It is the timeout for the manual and group modes, and it is cell 1's own expiry in the individual automatic modes.

Which configuration registers may be written depends on the active mode. Each register group is locked by a different set of mode encodings. A write to a locked register is dropped and raises a sticky reject flag. A threshold write that asks for minimum-cell auto-selection is also refused while a measurement scan is in progress.

Writing the mode register always restarts the timer at zero and clears the sticky status. Only a mode write clears that status.

Top module: `cbal_ctrl`

Register addresses with the default 14 cells:

| Address | Register |
|---|---|
| 0 | mode |
| 1 | switch mask |
| 2 | delay |
| 3 to 16 | cell expiration, cell n at 2+n |
| 17 | threshold |
| 18 | status (read only) |
| 19 | timer (read only) |
| 20 | live switch state (read only) |

## Requirements
- R1: After reset the mode is 000, every configuration register reads 0, the timer reads 0, all switch enables are 0, and reject_o is 0.
- R2: A write to address 0 always takes effect, and only wdata bits [2:0] are kept. Every mode write sets the timer to 0 on the same edge and clears the sticky finished flag (status bit 1) and the sticky reject flag (status bit 2).
- R3: Writes to the switch mask (address 1) and the delay (address 2) are dropped while the mode is 001 or 1xx. They are accepted in modes 000, 010 and 011.
- R4: Writes to cell 1's expiration (address 3) are dropped whenever the mode is not 000.
- R5: Writes to the expirations of cells 2 to 14 (addresses 4 to 16) and to the threshold (address 17) are dropped only while mode bit 2 is 1.
- R6: A threshold write with wdata bit 15 set (minimum-cell auto-select) is dropped while scan_active_i is 1, in any mode. With bit 15 clear, the write is not affected by scan_active_i.
- R7: A dropped write leaves the register unchanged. It sets reject_o and status bit 2, which stay set until the next mode write.
- R8: In modes 001, 010 and 011, sw_en_o equals the switch mask while the timer is below cell 1's expiration, and is 0 from then on. At that point the timer stops and status bit 1 sets.
- R9: In modes 1xx, sw_en_o bit n equals mask bit n while the timer is below cell n's expiration. When the timer has reached every cell's expiration, the timer stops and status bit 1 sets one cycle later. An expiration of 0 never turns its switch on.
- R10: In mode 000 sw_en_o is 0 and the timer is held at 0.
- R11: The timer (address 19) reads 0 right after a mode write. It then rises by one each cycle while the mode is not 000 and the operation is not finished. Status bit 0 is 1 during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for writes and reads |
| wdata_i | input | 16 | Write data |
| scan_active_i | input | 1 | A measurement scan is in progress |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| sw_en_o | output | 14 | Per-cell balancing switch enables |
| reject_o | output | 1 | Sticky flag: a write was refused |

## Verification
A table of writes is applied in every mode class: off, manual (001), group (010, 011) and individual automatic (1xx). Each write is read back and reject_o is compared. This separates the lock set of each register group: a lock decoded against the wrong encodings gives a wrong readback in exactly one mode class. Threshold writes are repeated with and without the auto-select bit while a scan is active, which tells the scan lock apart from the mode lock. Directed sequences then time the switch enables cycle by cycle in a group mode and an automatic mode with staggered expirations. Further sequences cover a restart while finished, a clear by disable, and all expirations at zero.

// File: rtl/cbal_pkg.sv
`timescale 1ns/1ps
package cbal_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_OFF    = 3'b000;
  localparam logic [MODE_W-1:0] MODE_MANUAL = 3'b001;

  // status word bit positions
  localparam int ST_RUN = 0;
  localparam int ST_FIN = 1;
  localparam int ST_REJ = 2;
  localparam int ST_W   = 3;

  // register map
  localparam int A_MODE = 0;
  localparam int A_SW   = 1;
  localparam int A_DLY  = 2;
  localparam int A_EXP0 = 3;

  function automatic int a_uv(input int cells);
    return A_EXP0 + cells;
  endfunction
  function automatic int a_stat(input int cells);
    return A_EXP0 + cells + 1;
  endfunction
  function automatic int a_timer(input int cells);
    return A_EXP0 + cells + 2;
  endfunction
  function automatic int a_swst(input int cells);
    return A_EXP0 + cells + 3;
  endfunction

  // switch mask and delay are frozen in manual and individual modes
  function automatic logic ctrl_locked(input logic [MODE_W-1:0] m);
    return (m == MODE_MANUAL) || m[2];
  endfunction
endpackage

// File: rtl/cbal_regs.sv
`timescale 1ns/1ps
module cbal_regs
  import cbal_pkg::*;
#(
  parameter int NUM_CELLS = 14,
  parameter int DATA_W    = 16,
  parameter int TIME_W    = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic                               scan_active_i,
  output logic [MODE_W-1:0]                  mode_o,
  output logic                               mode_wr_o,
  output logic                               blocked_o,
  output logic [NUM_CELLS-1:0]               sw_ctrl_o,
  output logic [DATA_W-1:0]                  dly_o,
  output logic [DATA_W-1:0]                  uv_o,
  output logic [NUM_CELLS-1:0][TIME_W-1:0]   exp_o
);
  localparam int A_UV = a_uv(NUM_CELLS);

  logic hit_sw, hit_dly, hit_uv;
  logic ctrl_ok, uv_ok;
  logic [NUM_CELLS-1:0] hit_exp, exp_ok;

  assign mode_wr_o = wr_en_i && (addr_i == ADDR_W'(A_MODE));
  assign hit_sw    = wr_en_i && (addr_i == ADDR_W'(A_SW));
  assign hit_dly   = wr_en_i && (addr_i == ADDR_W'(A_DLY));
  assign hit_uv    = wr_en_i && (addr_i == ADDR_W'(A_UV));
  assign ctrl_ok   = !ctrl_locked(mode_o);
  // auto-select request cannot be honoured while the scan may change min cell
  assign uv_ok     = !mode_o[2] && !(wdata_i[DATA_W-1] && scan_active_i);

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_exp
    assign hit_exp[g] = wr_en_i && (addr_i == ADDR_W'(A_EXP0 + g));
    if (g == 0) begin : g_first
      assign exp_ok[g] = (mode_o == MODE_OFF);
    end else begin : g_rest
      assign exp_ok[g] = !mode_o[2];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       exp_o[g] <= '0;
      else if (hit_exp[g] && exp_ok[g])  exp_o[g] <= wdata_i[TIME_W-1:0];
    end
  end

  assign blocked_o = ((hit_sw || hit_dly) && !ctrl_ok)
                   || (|(hit_exp & ~exp_ok))
                   || (hit_uv && !uv_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MODE_OFF;
      sw_ctrl_o <= '0;
      dly_o     <= '0;
      uv_o      <= '0;
    end else begin
      if (mode_wr_o)            mode_o    <= wdata_i[MODE_W-1:0];
      if (hit_sw && ctrl_ok)    sw_ctrl_o <= wdata_i[NUM_CELLS-1:0];
      if (hit_dly && ctrl_ok)   dly_o     <= wdata_i;
      if (hit_uv && uv_ok)      uv_o      <= wdata_i;
    end
  end
endmodule

// File: rtl/cbal_timer.sv
`timescale 1ns/1ps
module cbal_timer
  import cbal_pkg::*;
#(
  parameter int NUM_CELLS = 14,
  parameter int TIME_W    = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [MODE_W-1:0]                mode_i,
  input  logic                             restart_i,
  input  logic [NUM_CELLS-1:0]             sw_ctrl_i,
  input  logic [NUM_CELLS-1:0][TIME_W-1:0] exp_i,
  output logic [TIME_W-1:0]                timer_o,
  output logic [NUM_CELLS-1:0]             sw_en_o,
  output logic                             finished_o,
  output logic                             running_o
);
  logic [NUM_CELLS-1:0] live;
  logic                 active;

  assign active = (mode_i != MODE_OFF);

  // group/manual modes share cell 1's limit; individual modes use each cell's own
  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_live
    assign live[g] = timer_o < (mode_i[2] ? exp_i[g] : exp_i[0]);
  end

  assign finished_o = active && !(|live);
  assign running_o  = active && (|live);
  assign sw_en_o    = active ? (sw_ctrl_i & live) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          timer_o <= '0;
    else if (restart_i || !active)        timer_o <= '0;
    else if (running_o && !(&timer_o))    timer_o <= timer_o + 1'b1;
  end
endmodule

// File: rtl/cbal_status.sv
`timescale 1ns/1ps
module cbal_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wr_i,
  input  logic blocked_i,
  input  logic finished_i,
  output logic fin_o,
  output logic rej_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_o <= 1'b0;
      rej_o <= 1'b0;
    end else if (mode_wr_i) begin
      fin_o <= 1'b0;
      rej_o <= 1'b0;
    end else begin
      if (finished_i) fin_o <= 1'b1;
      if (blocked_i)  rej_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cbal_ctrl.sv
`timescale 1ns/1ps
module cbal_ctrl
  import cbal_pkg::*;
#(
  parameter int NUM_CELLS = 14,
  parameter int DATA_W    = 16,
  parameter int TIME_W    = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 scan_active_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_CELLS-1:0] sw_en_o,
  output logic                 reject_o
);
  localparam int A_UV    = a_uv(NUM_CELLS);
  localparam int A_STAT  = a_stat(NUM_CELLS);
  localparam int A_TIMER = a_timer(NUM_CELLS);
  localparam int A_SWST  = a_swst(NUM_CELLS);

  logic [MODE_W-1:0]                mode;
  logic                             mode_wr, blocked, finished, running, fin_q;
  logic [NUM_CELLS-1:0]             sw_ctrl;
  logic [DATA_W-1:0]                dly, uv;
  logic [NUM_CELLS-1:0][TIME_W-1:0] exp;
  logic [TIME_W-1:0]                timer;
  logic [ST_W-1:0]                  status;

  cbal_regs #(
    .NUM_CELLS(NUM_CELLS), .DATA_W(DATA_W), .TIME_W(TIME_W), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .scan_active_i,
    .mode_o(mode), .mode_wr_o(mode_wr), .blocked_o(blocked),
    .sw_ctrl_o(sw_ctrl), .dly_o(dly), .uv_o(uv), .exp_o(exp)
  );

  cbal_timer #(.NUM_CELLS(NUM_CELLS), .TIME_W(TIME_W)) i_timer (
    .clk_i, .rst_ni, .mode_i(mode), .restart_i(mode_wr), .sw_ctrl_i(sw_ctrl),
    .exp_i(exp), .timer_o(timer), .sw_en_o(sw_en_o),
    .finished_o(finished), .running_o(running)
  );

  cbal_status i_status (
    .clk_i, .rst_ni, .mode_wr_i(mode_wr), .blocked_i(blocked),
    .finished_i(finished), .fin_o(fin_q), .rej_o(reject_o)
  );

  always_comb begin
    status         = '0;
    status[ST_RUN] = running;
    status[ST_FIN] = fin_q;
    status[ST_REJ] = reject_o;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_MODE))  rdata_o = DATA_W'(mode);
    if (addr_i == ADDR_W'(A_SW))    rdata_o = DATA_W'(sw_ctrl);
    if (addr_i == ADDR_W'(A_DLY))   rdata_o = dly;
    if (addr_i == ADDR_W'(A_UV))    rdata_o = uv;
    if (addr_i == ADDR_W'(A_STAT))  rdata_o = DATA_W'(status);
    if (addr_i == ADDR_W'(A_TIMER)) rdata_o = DATA_W'(timer);
    if (addr_i == ADDR_W'(A_SWST))  rdata_o = DATA_W'(sw_en_o);
    for (int c = 0; c < NUM_CELLS; c++) begin
      if (addr_i == ADDR_W'(A_EXP0 + c)) rdata_o = DATA_W'(exp[c]);
    end
  end
endmodule

// File: rtl/cbal_ctrl_chk.sv
`timescale 1ns/1ps
module cbal_ctrl_chk
  import cbal_pkg::*;
#(
  parameter int NUM_CELLS = 14,
  parameter int DATA_W    = 16,
  parameter int TIME_W    = 16,
  parameter int ADDR_W    = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic                 scan_active_i,
  input logic [NUM_CELLS-1:0] sw_en_o,
  input logic                 reject_o,
  input logic [MODE_W-1:0]    mode_i,
  input logic [TIME_W-1:0]    timer_i,
  input logic [TIME_W-1:0]    exp0_i,
  input logic [NUM_CELLS-1:0] sw_ctrl_i,
  input logic                 finished_i
);
  localparam int A_UV = a_uv(NUM_CELLS);

  logic mode_wr;
  assign mode_wr = wr_en_i && (addr_i == ADDR_W'(A_MODE));

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (timer_i == '0) && !reject_o); // R2

  AST_CTRL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(A_SW) && (mode_i == MODE_MANUAL || mode_i[2]))
      |=> $stable(sw_ctrl_i) && reject_o); // R3

  AST_EXP1_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(A_EXP0) && mode_i != MODE_OFF)
      |=> $stable(exp0_i) && reject_o); // R4

  AST_UV_SCAN_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(A_UV) && wdata_i[DATA_W-1] && scan_active_i)
      |=> reject_o); // R6

  AST_REJ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reject_o && !mode_wr) |=> reject_o); // R7

  AST_FIN_SW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finished_i |-> (sw_en_o == '0)); // R9

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |-> (sw_en_o == '0) && (timer_i == '0)); // R10

  AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_OFF && !finished_i && !mode_wr && !(&timer_i))
      |=> timer_i == $past(timer_i) + 1'b1); // R11
endmodule

bind cbal_ctrl cbal_ctrl_chk #(
  .NUM_CELLS(NUM_CELLS), .DATA_W(DATA_W), .TIME_W(TIME_W), .ADDR_W(ADDR_W)
) i_cbal_ctrl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .scan_active_i(scan_active_i), .sw_en_o(sw_en_o),
  .reject_o(reject_o), .mode_i(mode), .timer_i(timer), .exp0_i(exp[0]),
  .sw_ctrl_i(sw_ctrl), .finished_i(finished)
);

// File: tb/test_cbal_ctrl.sv
`timescale 1ns/1ps
module test_cbal_ctrl;
  localparam int NC = 14;
  localparam logic [4:0] AM = 5'd0, ASW = 5'd1, ADL = 5'd2, AE1 = 5'd3, AE2 = 5'd4,
                         AE3 = 5'd5, AE14 = 5'd16, AUV = 5'd17, AST = 5'd18,
                         ATM = 5'd19, ASS = 5'd20;

  typedef struct packed {
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic        scan;
    logic [15:0] rd_exp;
    logic        rej_exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{ASW,  16'h0005, 1'b0, 16'h0005, 1'b0, 4'd3},  // R3 off: accepted
    '{ADL,  16'h1234, 1'b0, 16'h1234, 1'b0, 4'd3},  // R3
    '{AE1,  16'h0010, 1'b0, 16'h0010, 1'b0, 4'd4},  // R4
    '{AE2,  16'h0020, 1'b0, 16'h0020, 1'b0, 4'd5},  // R5
    '{AUV,  16'h0123, 1'b0, 16'h0123, 1'b0, 4'd5},  // R5
    '{AM,   16'hFFF9, 1'b0, 16'h0001, 1'b0, 4'd2},  // R2 upper bits dropped
    '{ASW,  16'h0009, 1'b0, 16'h0005, 1'b1, 4'd3},  // R3 manual: locked
    '{ADL,  16'h5555, 1'b0, 16'h1234, 1'b1, 4'd3},  // R3
    '{AE1,  16'h0044, 1'b0, 16'h0010, 1'b1, 4'd4},  // R4
    '{AE2,  16'h0030, 1'b0, 16'h0030, 1'b1, 4'd5},  // R5 open in manual, R7 sticky
    '{AM,   16'h0002, 1'b0, 16'h0002, 1'b0, 4'd7},  // R7 cleared by mode write
    '{ASW,  16'h0003, 1'b0, 16'h0003, 1'b0, 4'd3},  // R3 group: open
    '{AE1,  16'h0050, 1'b0, 16'h0010, 1'b1, 4'd4},  // R4 group: locked
    '{AM,   16'h0003, 1'b0, 16'h0003, 1'b0, 4'd2},  // R2
    '{ADL,  16'h0042, 1'b0, 16'h0042, 1'b0, 4'd3},  // R3 mode 011 open
    '{AM,   16'h0005, 1'b0, 16'h0005, 1'b0, 4'd2},  // R2
    '{AE14, 16'h0077, 1'b0, 16'h0000, 1'b1, 4'd5},  // R5 auto: locked
    '{AUV,  16'h0456, 1'b0, 16'h0123, 1'b1, 4'd5},  // R5
    '{ASW,  16'h000F, 1'b0, 16'h0003, 1'b1, 4'd3},  // R3
    '{AM,   16'h0000, 1'b0, 16'h0000, 1'b0, 4'd7},  // R7
    '{AE14, 16'h0077, 1'b0, 16'h0077, 1'b0, 4'd5},  // R5
    '{AUV,  16'h8456, 1'b1, 16'h0123, 1'b1, 4'd6},  // R6 auto-select during scan
    '{AUV,  16'h0456, 1'b1, 16'h0456, 1'b1, 4'd6},  // R6 plain write during scan
    '{AM,   16'h0000, 1'b0, 16'h0000, 1'b0, 4'd7},  // R7
    '{AUV,  16'h8456, 1'b0, 16'h8456, 1'b0, 4'd6}   // R6 no scan
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, scan = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [NC-1:0] sw_en;
  logic        reject;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cbal_ctrl i_cbal_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .scan_active_i(scan), .rdata_o(rdata), .sw_en_o(sw_en), .reject_o(reject)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic s);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; scan = s;
    @(posedge clk); #1;
    wr_en = 1'b0; scan = 1'b0;
  endtask

  task automatic chk_rd(input string req, input string what, input logic [4:0] a,
                        input logic [15:0] exp);
    addr = a; #1;
    chk(req, what, rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "sw_en", sw_en, 0);
    chk("R1", "reject", reject, 0);
    chk_rd("R1", "mode", AM, 0);
    chk_rd("R1", "exp1", AE1, 0);
    chk_rd("R1", "threshold", AUV, 0);
    chk_rd("R1", "timer", ATM, 0);
    chk_rd("R1", "status", AST, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].wdata, VECS[i].scan);
      addr = VECS[i].addr; #1;
      checks++;
      if (rdata !== VECS[i].rd_exp) begin
        errors++;
        $display("FAIL R%0d vec %0d readback: actual %0h expected %0h",
                 VECS[i].req, i, rdata, VECS[i].rd_exp);
      end
      checks++;
      if (reject !== VECS[i].rej_exp) begin
        errors++;
        $display("FAIL R%0d vec %0d reject: actual %0h expected %0h",
                 VECS[i].req, i, reject, VECS[i].rej_exp);
      end
    end

    // R8 group mode timing
    wr(ASW, 16'h0006, 1'b0);
    wr(AE1, 16'h0005, 1'b0);
    wr(AM, 16'h0002, 1'b0);
    chk("R8", "sw_en at start", sw_en, 16'h0006);
    chk_rd("R11", "timer at start", ATM, 0);
    chk_rd("R11", "status running", AST, 16'h0001);
    step(3);
    chk_rd("R11", "timer +3", ATM, 3);
    chk("R8", "sw_en at 3", sw_en, 16'h0006);
    step(2);
    chk("R8", "sw_en at limit", sw_en, 0);
    step(3);
    chk_rd("R8", "timer halted", ATM, 5);
    chk_rd("R8", "status finished", AST, 16'h0002);

    // R10 disable
    wr(AM, 16'h0000, 1'b0);
    chk("R10", "sw_en off", sw_en, 0);
    chk_rd("R10", "status off", AST, 0);

    // R9 individual auto mode, staggered expiry
    wr(ASW, 16'h0007, 1'b0);
    wr(AE1, 16'h0002, 1'b0);
    wr(AE2, 16'h0004, 1'b0);
    wr(AE3, 16'h0003, 1'b0);
    wr(AE14, 16'h0000, 1'b0);
    wr(AM, 16'h0004, 1'b0);
    chk("R9", "sw_en t0", sw_en, 16'h0007);
    step(2);
    chk("R9", "sw_en t2", sw_en, 16'h0006);
    step(1);
    chk("R9", "sw_en t3", sw_en, 16'h0002);
    step(1);
    chk("R9", "sw_en t4", sw_en, 0);
    step(3);
    chk_rd("R9", "timer halted", ATM, 4);
    chk_rd("R9", "status finished", AST, 16'h0002);
    chk_rd("R9", "switch state", ASS, 0);

    // R2 restart while finished
    wr(AM, 16'h0006, 1'b0);
    chk("R2", "sw_en restart", sw_en, 16'h0007);
    chk_rd("R2", "timer restart", ATM, 0);
    chk_rd("R2", "status restart", AST, 16'h0001);

    // R7 refused write during auto, cleared by disable
    wr(AE2, 16'h0009, 1'b0);
    chk("R7", "reject set", reject, 1);
    chk_rd("R7", "status with reject", AST, 16'h0005);
    chk_rd("R7", "exp2 kept", AE2, 16'h0004);
    wr(AM, 16'h0000, 1'b0);
    chk("R7", "reject cleared", reject, 0);
    step(3);
    chk_rd("R10", "timer held", ATM, 0);
    chk("R10", "sw_en held off", sw_en, 0);

    // R9 zero expiry everywhere
    wr(AE1, 16'h0000, 1'b0);
    wr(AE2, 16'h0000, 1'b0);
    wr(AE3, 16'h0000, 1'b0);
    wr(AM, 16'h0007, 1'b0);
    chk("R9", "zero expiry sw_en", sw_en, 0);
    chk_rd("R9", "zero expiry status t0", AST, 0);
    step(1);
    chk_rd("R9", "zero expiry status t1", AST, 16'h0002);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule